// File: doc/BRIEF.md
# Hamming 12-bit codeword corrector

The block checks a 12-bit Hamming codeword that carries 8 data bits and 4 parity bits. When it sees an input strobe, it computes four parity checks over the received word and packs them into a 4-bit syndrome. If the syndrome names a bit inside the word, the block inverts that bit. One clock later it presents the repaired word, the 8 recovered data bits, the syndrome and one of three status flags: clean, fixed or uncorrectable. A syndrome of 13, 14 or 15 names a position the word does not have. Such a word is reported as a certain double error and is passed through unchanged. A separate combinational encoder builds codewords with the same bit layout.

Codeword position p (1..12) is carried on bit p-1 of every codeword vector. Parity bits sit at positions 1, 2, 4 and 8. Data bits D0..D7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. A small controller has two states:

- ST_IDLE: no result is being presented.
- ST_EMIT: a fresh result is being presented.

Its transitions are:

- IDLE→EMIT on a strobe.
- EMIT→EMIT on a back-to-back strobe.
- EMIT→IDLE when no strobe arrives.
- IDLE→IDLE when no strobe arrives.

Top module: `hm12_decoder`

## Requirements
- R1: While reset is asserted (rst_n low) and after it, until the first strobe: out_valid, out_clean, out_fixed and out_uncorr are 0, and out_code, out_data and out_syndrome are 0.
- R2: out_valid is 1 in exactly the cycle after each clock edge at which in_valid was 1, and 0 otherwise. Back-to-back strobes give back-to-back results.
- R3: A word with syndrome 0 raises out_clean, and out_code equals the received word.
- R4: A syndrome s with 1 ≤ s ≤ 12 raises out_fixed, and out_code equals the received word with bit s-1 inverted.
- R5: A syndrome of 13, 14 or 15 raises out_uncorr, and out_code equals the received word unchanged.
- R6: out_data bit k is taken from out_code at positions 3, 5, 6, 7, 9, 10, 11, 12 for k = 0..7.
- R7: out_syndrome bit i is the XOR of all received positions p whose index has bit i set.
- R8: While out_valid is 1, exactly one of out_clean, out_fixed, out_uncorr is 1.
- R9: Without a strobe, out_code, out_data, out_syndrome and the flags hold their previous values.
- R10: The encoder places the data at the positions of R6 and sets the parity bit at position 2^i so that syndrome bit i is 0; every encoded word decodes as clean.
- R11: A double error at positions 1 and 2 gives syndrome 3 and is reported as fixed, with D0 inverted. This aliasing is expected behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: in_code is to be decoded |
| in_code | input | 12 | Received codeword, position p on bit p-1 |
| out_valid | output | 1 | One-cycle pulse: a new result is presented |
| out_code | output | 12 | Corrected (or passed-through) codeword |
| out_data | output | 8 | Data bits D0..D7 taken from out_code |
| out_syndrome | output | 4 | Syndrome of the received word |
| out_clean | output | 1 | Syndrome was zero |
| out_fixed | output | 1 | One bit was inverted |
| out_uncorr | output | 1 | Syndrome pointed outside the word |

## Verification
The bench builds the block with its defaults, 8 data bits and 4 parity bits. This leaves three syndrome values beyond the last position, so the out-of-range path is reachable with ordinary double errors: positions 12 with 1, 2 or 3. At this size every single-error position can be swept for several data patterns. The P0+P1 aliasing case and back-to-back strobes followed by idle gaps are also short enough to cover directly.

// File: rtl/hm12_pkg.sv
package hm12_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } hm_state_e;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_CLEAN  = 2'd1,
        CLS_FIXED  = 2'd2,
        CLS_UNCORR = 2'd3
    } hm_class_e;

    // Position (1-based) of the k-th data bit: k-th index that is not a power of two.
    function automatic int hm_data_pos(input int k, input int code_w);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p <= code_w; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == k) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Bit p-1 is set when position p takes part in check i.
    function automatic logic [31:0] hm_check_mask(input int i, input int code_w);
        logic [31:0] m;
        m = '0;
        for (int p = 1; p <= code_w; p++) begin
            if (((p >> i) & 1) == 1) m[p-1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hm_encoder.sv
module hm_encoder
    import hm12_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAR_W  = 4,
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] placed;

    always_comb begin
        placed = '0;
        for (int k = 0; k < DATA_W; k++) begin
            placed[hm_data_pos(k, CODE_W) - 1] = data[k];
        end
    end

    always_comb begin
        code = placed;
        for (int i = 0; i < PAR_W; i++) begin
            code[(1 << i) - 1] = ^(32'(placed) & hm_check_mask(i, CODE_W));
        end
    end

endmodule

// File: rtl/hm_syndrome.sv
module hm_syndrome
    import hm12_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int PAR_W  = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [PAR_W-1:0]  syn
);

    for (genvar gi = 0; gi < PAR_W; gi++) begin : g_check
        localparam logic [31:0] MASK = hm_check_mask(gi, CODE_W);
        assign syn[gi] = ^(32'(code) & MASK);
    end

endmodule

// File: rtl/hm_corrector.sv
module hm_corrector
    import hm12_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAR_W  = 4,
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic [CODE_W-1:0] code_in,
    input  logic [PAR_W-1:0]  syn,
    output logic [CODE_W-1:0] code_out,
    output logic [DATA_W-1:0] data_out,
    output hm_class_e         cls
);

    localparam logic [PAR_W-1:0] LAST_POS = PAR_W'(CODE_W);

    logic [CODE_W-1:0] flip;
    logic              out_of_range;

    for (genvar gp = 1; gp <= CODE_W; gp++) begin : g_flip
        assign flip[gp-1] = (syn == PAR_W'(gp));
    end

    assign out_of_range = (syn > LAST_POS);

    always_comb begin
        if (syn == '0) begin
            cls      = CLS_CLEAN;
            code_out = code_in;
        end else if (out_of_range) begin
            cls      = CLS_UNCORR;
            code_out = code_in;
        end else begin
            cls      = CLS_FIXED;
            code_out = code_in ^ flip;
        end
    end

    for (genvar gk = 0; gk < DATA_W; gk++) begin : g_extract
        localparam int POS = hm_data_pos(gk, CODE_W);
        assign data_out[gk] = code_out[POS-1];
    end

endmodule

// File: rtl/hm12_decoder.sv
module hm12_decoder
    import hm12_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAR_W  = 4,
    localparam int CODE_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code,
    output logic [DATA_W-1:0] out_data,
    output logic [PAR_W-1:0]  out_syndrome,
    output logic              out_clean,
    output logic              out_fixed,
    output logic              out_uncorr
);

    hm_state_e         state_q, state_nx;
    hm_class_e         cls_c, cls_q;
    logic [PAR_W-1:0]  syn_c;
    logic [CODE_W-1:0] code_c;
    logic [DATA_W-1:0] data_c;

    hm_syndrome #(.CODE_W(CODE_W), .PAR_W(PAR_W)) i_syndrome (
        .code (in_code),
        .syn  (syn_c)
    );

    hm_corrector #(.DATA_W(DATA_W), .PAR_W(PAR_W)) i_corrector (
        .code_in  (in_code),
        .syn      (syn_c),
        .code_out (code_c),
        .data_out (data_c),
        .cls      (cls_c)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code     <= '0;
            out_data     <= '0;
            out_syndrome <= '0;
            cls_q        <= CLS_NONE;
        end else if (in_valid) begin
            out_code     <= code_c;
            out_data     <= data_c;
            out_syndrome <= syn_c;
            cls_q        <= cls_c;
        end
    end

    assign out_valid  = (state_q == ST_EMIT);
    assign out_clean  = (cls_q == CLS_CLEAN);
    assign out_fixed  = (cls_q == CLS_FIXED);
    assign out_uncorr = (cls_q == CLS_UNCORR);

endmodule

// File: rtl/hm12_decoder_chk.sv
module hm12_decoder_chk #(
    parameter int CODE_W = 12,
    parameter int PAR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CODE_W-1:0] in_code,
    input logic              out_valid,
    input logic [CODE_W-1:0] out_code,
    input logic [PAR_W-1:0]  out_syndrome,
    input logic              out_clean,
    input logic              out_fixed,
    input logic              out_uncorr
);

    localparam logic [PAR_W-1:0] LAST_POS = PAR_W'(CODE_W);

    assert_strobe_to_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_clean_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_clean || (out_code == $past(in_code) && out_syndrome == '0)));

    assert_fix_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_fixed || $countones(out_code ^ $past(in_code)) == 1));

    assert_uncorr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_uncorr || (out_syndrome > LAST_POS && out_code == $past(in_code))));

    assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_clean, out_fixed, out_uncorr}) == 1);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code) && $stable(out_syndrome));

endmodule

bind hm12_decoder hm12_decoder_chk #(.CODE_W(CODE_W), .PAR_W(PAR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_code      (in_code),
    .out_valid    (out_valid),
    .out_code     (out_code),
    .out_syndrome (out_syndrome),
    .out_clean    (out_clean),
    .out_fixed    (out_fixed),
    .out_uncorr   (out_uncorr)
);

// File: tb/test_hm12_decoder.sv
module test_hm12_decoder;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [11:0] in_code;
    logic        out_valid;
    logic [11:0] out_code;
    logic [7:0]  out_data;
    logic [3:0]  out_syndrome;
    logic        out_clean;
    logic        out_fixed;
    logic        out_uncorr;
    logic [7:0]  enc_data;
    logic [11:0] enc_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    hm12_decoder i_hm12_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_code      (in_code),
        .out_valid    (out_valid),
        .out_code     (out_code),
        .out_data     (out_data),
        .out_syndrome (out_syndrome),
        .out_clean    (out_clean),
        .out_fixed    (out_fixed),
        .out_uncorr   (out_uncorr)
    );

    hm_encoder i_hm_encoder (
        .data (enc_data),
        .code (enc_code)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Reference model, written from the requirements
    function automatic int dpos(input int k);
        int tbl[8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        return tbl[k];
    endfunction

    function automatic logic [3:0] ref_syn(input logic [11:0] c);
        logic [3:0] s;
        s = '0;
        for (int i = 0; i < 4; i++)
            for (int p = 1; p <= 12; p++)
                if (((p >> i) & 1) == 1) s[i] = s[i] ^ c[p-1];
        return s;
    endfunction

    function automatic logic [11:0] ref_enc(input logic [7:0] d);
        logic [11:0] c;
        logic [3:0]  s;
        c = '0;
        for (int k = 0; k < 8; k++) c[dpos(k)-1] = d[k];
        s = ref_syn(c);
        for (int i = 0; i < 4; i++) c[(1 << i) - 1] = s[i];
        return c;
    endfunction

    function automatic logic [7:0] ref_data(input logic [11:0] c);
        logic [7:0] d;
        for (int k = 0; k < 8; k++) d[k] = c[dpos(k)-1];
        return d;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One strobe; results are sampled at the next falling edge
    task automatic strobe(input logic [11:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_code  = c;
        @(negedge clk);
        in_valid = 1'b0;
        in_code  = '0;
    endtask

    task automatic check_result(input string req, input logic [11:0] rx,
                                input logic [11:0] exp_code, input logic [1:0] exp_cls);
        chk("R2", "out_valid", 32'(out_valid), 32'd1);
        chk(req, "out_code", 32'(out_code), 32'(exp_code));
        chk("R6", "out_data", 32'(out_data), 32'(ref_data(exp_code)));
        chk("R7", "out_syndrome", 32'(out_syndrome), 32'(ref_syn(rx)));
        chk("R8", "flags", 32'({out_uncorr, out_fixed, out_clean}),
            32'(exp_cls == 2'd1 ? 3'b001 : exp_cls == 2'd2 ? 3'b010 : 3'b100));
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_code = '0;
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        chk("R1", "flags in reset", 32'({out_uncorr, out_fixed, out_clean}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_code after reset", 32'(out_code), 32'd0);
        chk("R1", "out_data/syn after reset", 32'({out_data, out_syndrome}), 32'd0);
        chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_clean;
        logic [7:0] pats[6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        foreach (pats[n]) begin
            enc_data = pats[n];
            #1;
            chk("R10", "encoder", 32'(enc_code), 32'(ref_enc(pats[n])));
            strobe(enc_code);
            check_result("R3", enc_code, ref_enc(pats[n]), 2'd1);
        end
    endtask

    task automatic t_single;
        logic [7:0] pats[3] = '{8'h3C, 8'hC3, 8'h96};
        foreach (pats[n]) begin
            for (int p = 1; p <= 12; p++) begin
                logic [11:0] good;
                logic [11:0] bad;
                good = ref_enc(pats[n]);
                bad = good ^ (12'd1 << (p - 1));
                strobe(bad);
                check_result("R4", bad, good, 2'd2);
                chk("R4", "syndrome names position", 32'(out_syndrome), 32'(p));
            end
        end
    endtask

    task automatic t_uncorr;
        int other[3] = '{1, 2, 3};
        foreach (other[n]) begin
            logic [11:0] bad;
            bad = ref_enc(8'h69) ^ 12'h800 ^ (12'd1 << (other[n] - 1));
            strobe(bad);
            check_result("R5", bad, bad, 2'd3);
            chk("R5", "syndrome out of range", 32'(out_syndrome), 32'(12 + other[n]));
        end
    endtask

    task automatic t_alias;
        logic [11:0] good;
        logic [11:0] bad;
        good = ref_enc(8'h4E);
        bad = good ^ 12'b0000_0000_0011;
        strobe(bad);
        check_result("R11", bad, bad ^ 12'b0000_0000_0100, 2'd2);
        chk("R11", "syndrome 3", 32'(out_syndrome), 32'd3);
        chk("R11", "D0 inverted", 32'(out_data), 32'(8'h4E ^ 8'h01));
    endtask

    task automatic t_timing;
        logic [11:0] w[3];
        w[0] = ref_enc(8'h11);
        w[1] = ref_enc(8'h22) ^ 12'h010;
        w[2] = ref_enc(8'h33);
        @(negedge clk);
        for (int n = 0; n < 3; n++) begin
            in_valid = 1'b1;
            in_code  = w[n];
            @(negedge clk);
            if (n > 0) chk("R2", "back-to-back valid", 32'(out_valid), 32'd1);
        end
        in_valid = 1'b0;
        in_code  = 12'hFFF;
        chk("R2", "last of burst valid", 32'(out_valid), 32'd1);
        chk("R2", "last of burst code", 32'(out_code), 32'(w[2]));
        repeat (3) begin
            @(negedge clk);
            chk("R2", "valid low when idle", 32'(out_valid), 32'd0);
            chk("R9", "code held", 32'(out_code), 32'(w[2]));
            chk("R9", "data/syn/flags held",
                32'({out_data, out_syndrome, out_uncorr, out_fixed, out_clean}),
                32'({8'h33, 4'd0, 3'b001}));
        end
        in_code = '0;
    endtask

    initial begin
        t_reset;
        t_clean;
        t_single;
        t_uncorr;
        t_alias;
        t_timing;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule